// File: doc/BRIEF.md
# Serial Crosspoint Configuration Loader

This block is the serial control path of an eight-output routing switch. A host shifts a 32-bit configuration frame in through one data pin, one bit for each qualified rising edge of a write strobe. The strobe is gated by two select inputs, one active high and one active low. The shifted bits build up in a first-rank shift chain. The last stage of that chain drives a serial output, so that several loaders can be wired in a daisy chain. The frame for output 0 goes in first and the frame for output 7 goes in last. Each 4-bit field is sent most significant bit first.

A latch event copies the first rank into a second rank, one stored 4-bit command per output. Each output's command is decoded into a 3-bit source index, a ground-select flag and an enable flag. Codes 0 to 7 pick a source. Code 8 grounds the output. Code 9 grounds the output and turns it on. Code 10 turns the output off. Codes 11 to 15 are illegal: if any field in the first rank holds one, the whole transfer is refused.

The latch works in one of two modes. In edge mode a transfer happens on a rising edge of the latch input. In level mode the second rank reloads on every clock while latch is low.

Top module: `xpt_serial_loader`

## Requirements
- R1: A frame is 32 bits long. After 32 qualified shifts, the field for output k is the k-th 4-bit group sent, counting from 0. Bit 3 of each group is sent first, so output 0's field occupies the first four bits sent.
- R2: The chain shifts by one bit only on a clock that sees a rising edge of (wr_strb AND sel_hi AND NOT sel_lo_n). Strobes seen while sel_hi=0 or sel_lo_n=1 leave the chain unchanged. A strobe level held through reset is not an edge.
- R3: After a transfer, an output with code 0000 to 0111 has route_sel equal to the code and gnd_sel=0, and its enable is unchanged. Output k uses route_sel bits [3k+2:3k], and gnd_sel and out_en bit k.
- R4: Code 1000 gives gnd_sel=1 and route_sel=0, and leaves the enable unchanged.
- R5: Code 1001 gives out_en=1 and gnd_sel=1. Code 1010 gives out_en=0 and gnd_sel=1, and the stored command becomes 1010.
- R6: If any first-rank field holds 1011 to 1111, a latch event changes no output.
- R7: With edge_mode=1, the second rank loads only on a clock that sees latch_in rise. The outputs show the new value right after that edge. A latch held high, or a latch that falls, causes no load.
- R8: With edge_mode=0, the second rank loads on every clock while latch_in=0 and holds while latch_in=1.
- R9: ser_out is the last stage of the chain. After the n-th qualified shift (n ≥ 32), ser_out equals the bit that was shifted in at shift n-31.
- R10: After reset, out_en=0 and gnd_sel=1 for every output, and route_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_strb | input | 1 | Write strobe; its qualified rising edge shifts one bit |
| sel_hi | input | 1 | Active-high select that gates the strobe |
| sel_lo_n | input | 1 | Active-low select that gates the strobe |
| ser_in | input | 1 | Serial data in |
| latch_in | input | 1 | Transfer control for the second rank |
| edge_mode | input | 1 | 1 = transfer on latch rise, 0 = transfer while latch is low |
| ser_out | output | 1 | Last stage of the shift chain, for cascading |
| route_sel | output | 24 | Source index, 3 bits per output |
| gnd_sel | output | 8 | Ground select, 1 bit per output |
| out_en | output | 8 | Output enable, 1 bit per output |

## Verification
A strobe or latch level sampled at clock edge N is compared with its registered copy at that same edge. The chain, ser_out and the second rank therefore all change at edge N, and the outputs are valid one time step after it. Every bench task drives its inputs on the falling edge and samples 1 ns after the rising edge that should act. Each bit takes two clocks, one with the strobe high and one with it low, so every shift sees a fresh edge. In level mode, the load is checked one clock after latch goes low, and the hold is checked while latch stays high.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned NUM_OUT = 8;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned FRAME_W = NUM_OUT * CMD_W;

  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t CMD_GND = 4'd8;
  localparam cmd_t CMD_ON  = 4'd9;
  localparam cmd_t CMD_OFF = 4'd10;

  // a command above the disable code is not allowed to reach the second rank
  function automatic logic cmd_illegal(input cmd_t c);
    return c > CMD_OFF;
  endfunction

  function automatic logic [SRC_W-1:0] cmd_route(input cmd_t c);
    return c[CMD_W-1] ? '0 : c[SRC_W-1:0];
  endfunction

  function automatic logic cmd_ground(input cmd_t c);
    return c[CMD_W-1];
  endfunction

  function automatic logic cmd_enable_next(input cmd_t c, input logic cur);
    if (c == CMD_ON)  return 1'b1;
    if (c == CMD_OFF) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/xpt_rise_det.sv
module xpt_rise_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xpt_shift_chain.sv
module xpt_shift_chain #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] chain,
  output logic             dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chain <= '0;
    else if (step) chain <= {chain[WIDTH-2:0], din};
  end

  assign dout = chain[WIDTH-1];

  // R2: no qualified strobe, no movement
  p_chain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(chain));
  // R9: serial output takes the bit from the stage below on a shift
  p_serout_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> dout == $past(chain[WIDTH-2]));
  // R1: new bit enters at the bottom of the chain
  p_din_enters_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> chain[0] == $past(din));
endmodule

// File: rtl/xpt_out_slot.sv
module xpt_out_slot
  import xpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cmd_t             cmd_in,
  output logic [SRC_W-1:0] route,
  output logic             gnd,
  output logic             en
);
  cmd_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= CMD_OFF;
      en   <= 1'b0;
    end else if (load) begin
      held <= cmd_in;
      en   <= cmd_enable_next(cmd_in, en);
    end
  end

  assign route = cmd_route(held);
  assign gnd   = cmd_ground(held);

  // R3: source codes route and keep the enable
  p_route_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load && !cmd_in[CMD_W-1] |=> route == $past(cmd_in[SRC_W-1:0]) && !gnd && en == $past(en));
  // R4: ground code keeps the enable
  p_gnd_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && cmd_in == CMD_GND |=> gnd && route == '0 && en == $past(en));
  // R5: turn on / turn off
  p_turn_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && cmd_in == CMD_ON |=> en && gnd);
  p_turn_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && cmd_in == CMD_OFF |=> !en && gnd);
  // second rank moves only on a load
  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(route) && $stable(gnd) && $stable(en));
endmodule

// File: rtl/xpt_serial_loader.sv
module xpt_serial_loader
  import xpt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_strb,
  input  logic                       sel_hi,
  input  logic                       sel_lo_n,
  input  logic                       ser_in,
  input  logic                       latch_in,
  input  logic                       edge_mode,
  output logic                       ser_out,
  output logic [NUM_OUT*SRC_W-1:0]   route_sel,
  output logic [NUM_OUT-1:0]         gnd_sel,
  output logic [NUM_OUT-1:0]         out_en
);
  logic               wr_gated, shift_evt, latch_rise;
  logic               xfer_req, any_bad, xfer;
  logic [FRAME_W-1:0] rank1;

  assign wr_gated = wr_strb & sel_hi & ~sel_lo_n;

  xpt_rise_det #(.RST_VAL(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(wr_gated), .rise(shift_evt));

  xpt_rise_det #(.RST_VAL(1'b1)) u_latch_edge (
    .clk(clk), .rst_n(rst_n), .lvl(latch_in), .rise(latch_rise));

  xpt_shift_chain #(.WIDTH(FRAME_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(shift_evt), .din(ser_in),
    .chain(rank1), .dout(ser_out));

  // first field sent ends at the top of the chain
  always_comb begin
    any_bad = 1'b0;
    for (int k = 0; k < NUM_OUT; k++)
      any_bad |= cmd_illegal(rank1[FRAME_W-1-k*CMD_W -: CMD_W]);
  end

  assign xfer_req = edge_mode ? latch_rise : ~latch_in;
  assign xfer     = xfer_req & ~any_bad;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
    xpt_out_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (xfer),
      .cmd_in(rank1[FRAME_W-1-k*CMD_W -: CMD_W]),
      .route (route_sel[k*SRC_W +: SRC_W]),
      .gnd   (gnd_sel[k]),
      .en    (out_en[k]));
  end

  // R6: an illegal field blocks the whole transfer
  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && any_bad |=> $stable(route_sel) && $stable(gnd_sel) && $stable(out_en));
  // R7: edge mode moves nothing without a latch rise
  p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && !latch_rise |=> $stable(route_sel) && $stable(gnd_sel) && $stable(out_en));
  // R8: level mode holds while latch is high
  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode && latch_in |=> $stable(route_sel) && $stable(gnd_sel) && $stable(out_en));
  // R2: chain is steady unless a gated strobe rose
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gated |=> $stable(rank1));
endmodule

// File: tb/test_xpt_serial_loader.sv
module test_xpt_serial_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strb = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0, ser_in = 1'b0;
  logic        latch_in = 1'b0, edge_mode = 1'b1;
  logic        ser_out;
  logic [23:0] route_sel;
  logic [7:0]  gnd_sel, out_en;

  int total = 0, bad = 0;
  logic       done = 1'b0;
  logic [2:0] m_route [8];
  logic [7:0] m_gnd, m_en;

  always #2.5 clk = ~clk;

  xpt_serial_loader i_xpt_serial_loader (
    .clk(clk), .rst_n(rst_n), .wr_strb(wr_strb), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .ser_in(ser_in), .latch_in(latch_in),
    .edge_mode(edge_mode), .ser_out(ser_out), .route_sel(route_sel),
    .gnd_sel(gnd_sel), .out_en(out_en));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] pack_frame(input logic [3:0] f [8]);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[31-4*k -: 4] = f[k];
    return w;
  endfunction

  function automatic logic [31:0] fill_frame(input logic [3:0] c);
    logic [3:0] f [8];
    for (int k = 0; k < 8; k++) f[k] = c;
    return pack_frame(f);
  endfunction

  // model: what the rules say a transfer of this frame does
  task automatic model_apply(input logic [31:0] w);
    logic blocked = 1'b0;
    for (int k = 0; k < 8; k++) if (w[31-4*k -: 4] >= 4'd11) blocked = 1'b1;
    if (!blocked)
      for (int k = 0; k < 8; k++) begin
        logic [3:0] c = w[31-4*k -: 4];
        m_route[k] = (c < 4'd8) ? c[2:0] : 3'd0;
        m_gnd[k]   = (c >= 4'd8);
        if (c == 4'd9)  m_en[k] = 1'b1;
        if (c == 4'd10) m_en[k] = 1'b0;
      end
  endtask

  task automatic chk_outs(input string tag);
    logic [23:0] r;
    for (int k = 0; k < 8; k++) r[3*k +: 3] = m_route[k];
    chk({tag, " route"}, {8'd0, route_sel}, {8'd0, r});
    chk({tag, " gnd"}, {24'd0, gnd_sel}, {24'd0, m_gnd});
    chk({tag, " en"}, {24'd0, out_en}, {24'd0, m_en});
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b; wr_strb = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); wr_strb = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic shift_frame(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_latch;
    @(negedge clk); latch_in = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); latch_in = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) m_route[k] = 3'd0;
    m_gnd = 8'hFF; m_en = 8'h00;
    chk_outs("R10 reset");
  endtask

  task automatic t_order;
    logic [3:0] f [8];
    logic [31:0] w = fill_frame(4'd9);
    shift_frame(w); pulse_latch(); model_apply(w);
    chk_outs("R5 all on");
    for (int k = 0; k < 8; k++) f[k] = 4'(7 - k);
    w = pack_frame(f);
    shift_frame(w); pulse_latch(); model_apply(w);
    chk_outs("R1 R3 field order");
  endtask

  task automatic t_gnd_off;
    logic [3:0] f [8];
    logic [31:0] w;
    for (int k = 0; k < 8; k++) f[k] = 4'd3;
    f[0] = 4'd8; f[1] = 4'd10;
    w = pack_frame(f);
    shift_frame(w); pulse_latch(); model_apply(w);
    chk_outs("R4 R5 ground and off");
    chk("R4 out0 enable kept", {31'd0, out_en[0]}, 32'd1);
  endtask

  task automatic t_gate;
    logic [31:0] w;
    for (int k = 0; k < 8; k++) w[31-4*k -: 4] = (k == 0) ? 4'd8 : (k == 1) ? 4'd10 : 4'd3;
    @(negedge clk); sel_hi = 1'b0;
    for (int i = 0; i < 4; i++) shift_bit(1'b0);
    @(negedge clk); sel_hi = 1'b1; sel_lo_n = 1'b1;
    for (int i = 0; i < 4; i++) shift_bit(1'b0);
    @(negedge clk); sel_lo_n = 1'b0;
    pulse_latch(); model_apply(w);
    chk_outs("R2 gated strobes ignored");
  endtask

  task automatic t_block;
    logic [31:0] w = 32'h0;
    w[31-4*5 -: 4] = 4'b1100;
    shift_frame(w); pulse_latch(); model_apply(w);
    chk_outs("R6 illegal field blocks");
  endtask

  task automatic t_edge;
    logic [31:0] w = fill_frame(4'd2);
    shift_frame(w);
    chk_outs("R7 no rise no load");
    @(negedge clk); latch_in = 1'b1;
    @(posedge clk); #1;
    model_apply(w);
    chk_outs("R7 load on rise");
    shift_frame(fill_frame(4'd1));
    chk_outs("R7 latch held high");
  endtask

  task automatic t_level;
    @(negedge clk); edge_mode = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk_outs("R8 hold while high");
    @(negedge clk); latch_in = 1'b0;
    @(posedge clk); #1;
    model_apply(fill_frame(4'd1));
    chk_outs("R8 load while low");
    @(negedge clk); latch_in = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_serial;
    logic [31:0] a = 32'hA5C3_0F96, b = 32'h3C69_F0A5;
    int miss = 0;
    shift_frame(a);
    chk("R9 first bit out", {31'd0, ser_out}, {31'd0, a[31]});
    for (int m = 1; m < 32; m++) begin
      shift_bit(b[32-m]);
      if (ser_out !== a[31-m]) miss++;
    end
    chk("R9 cascade stream", miss, 0);
    chk_outs("R8 outputs held during cascade");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_order();
    t_gnd_off();
    t_gate();
    t_block();
    t_edge();
    t_level();
    t_serial();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule